// File: doc/BRIEF.md
# Momentum Node Occupancy Arbiter

This block decides which committing transaction owns each of a set of memory nodes. Each requester shows a bitmask of the nodes its commit needs, and it asks for all of them at once. Its momentum is the number of nodes it holds at that moment. A free node goes to a contender at once. A node that someone already holds can be taken only by a contender whose momentum is strictly higher than the holder's. The transaction that holds the most nodes therefore always has a way to finish. This rules out deadlock and livelock without any fixed acquisition order.

Each requester sees its own occupied nodes, its momentum, a flag raised when it holds its whole commit set, and a one-cycle notice when it loses a node to a steal. When the commit completes, a done strobe gives back everything the requester holds. All outputs change on the same clock edge that updates ownership.

Top module: `occ_momentum_arbiter`

## Requirements
- R1: A node belongs to at most one requester at any time, so the held masks of different requesters never overlap.
- R2: A requester contends for every node of its commit set in the same cycle. Bit r*NUM_NODES+n of `commit_set` and of `held` refers to node n of requester r. A free node is owned from the next edge, and when several requesters want the same free node, the lowest requester index wins it.
- R3: `momentum[r*MOM_W +: MOM_W]` equals the number of bits set in requester r's held mask, and it changes on the same edge as that mask.
- R4: A contender takes a held node only if its momentum is strictly greater than the holder's. Equal or lower momentum leaves the node where it is.
- R5: When several contenders may steal the same node in one cycle, the one with the highest momentum wins, and the lowest index wins among equal momenta. A node changes hands at most once per cycle.
- R6: A requester that loses a node to a steal sees `stolen` high for exactly the cycle after the steal edge. Its momentum drops by the number of nodes it lost. It keeps contending for those nodes but cannot win them back while the new holder's momentum is higher or equal.
- R7: `all_held[r]` is high when requester r was valid, had a non-empty commit set and not done, and its held mask equals that set. An empty commit set never raises it.
- R8: A done strobe frees every node of that requester at the next edge. A freed node is not handed to anyone on that same edge, and a holder's done cancels any steal of its nodes in that cycle, so no `stolen` pulse is raised.
- R9: A synchronous active-high reset leaves every node free and clears `held`, `momentum`, `all_held` and `stolen`.
- R10: A requester gains a node only if, in the cycle before, it was valid, had that node in its commit set, and was not done.
- R11: Steal decisions compare the momenta registered at the start of the cycle. Nodes won on the same edge do not count until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_REQ | Requester is committing and contending |
| commit_set | input | NUM_REQ*NUM_NODES | Per-requester node bitmask |
| commit_done | input | NUM_REQ | Release all nodes of the requester |
| held | output | NUM_REQ*NUM_NODES | Per-requester occupied nodes |
| momentum | output | NUM_REQ*MOM_W | Per-requester count of held nodes |
| all_held | output | NUM_REQ | Whole commit set is occupied |
| stolen | output | NUM_REQ | One-cycle notice that a node was taken away |

## Verification
Two events can meet on the same node in one cycle: a steal by a contender with higher momentum, and the done strobe of the current holder. The bench sets this up by raising the holder's done while a contender that outranks it wants the node. It then expects the node to be free, with no `stolen` pulse, and expects the contender to win it one edge later. A second overlap is a free-node grant and a steal in the same cycle. Here the bench confirms that the newly won node does not raise momentum until the following cycle, which delays the steal by one edge.

// File: rtl/occ_arb_pkg.sv
package occ_arb_pkg;

  // Per-node action chosen in one cycle
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_TAKE  = 2'd1,
    ACT_STEAL = 2'd2,
    ACT_FREE  = 2'd3
  } slot_act_e;

endpackage

// File: rtl/occ_node_slot.sv
module occ_node_slot
  import occ_arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int MOM_W   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ-1:0]       want,
  input  logic [NUM_REQ-1:0]       done,
  input  logic [NUM_REQ*MOM_W-1:0] mom,
  output logic [NUM_REQ-1:0]       owner_oh,
  output logic [NUM_REQ-1:0]       next_oh,
  output logic [NUM_REQ-1:0]       lose_oh
);

  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;

  logic             own_v;
  logic [IDX_W-1:0] own_id;

  slot_act_e        act;
  logic [IDX_W-1:0] win_id;
  logic [MOM_W-1:0] holder_mom;
  logic [MOM_W-1:0] best_mom;
  logic             found;

  assign owner_oh = own_v ? (NUM_REQ'(1) << own_id) : '0;

  // Choose this cycle's action from registered momenta
  always_comb begin
    act        = ACT_HOLD;
    win_id     = '0;
    best_mom   = '0;
    found      = 1'b0;
    holder_mom = mom[int'(own_id)*MOM_W +: MOM_W];
    if (own_v && done[own_id]) begin
      act = ACT_FREE;
    end else if (!own_v) begin
      // descending scan leaves the lowest index as winner
      for (int r = NUM_REQ-1; r >= 0; r--) begin
        if (want[r]) begin
          found  = 1'b1;
          win_id = IDX_W'(r);
        end
      end
      if (found) act = ACT_TAKE;
    end else begin
      // ascending scan with strict compare keeps lowest index on ties
      for (int r = 0; r < NUM_REQ; r++) begin
        if (want[r] && (IDX_W'(r) != own_id) &&
            (mom[r*MOM_W +: MOM_W] > holder_mom) &&
            (!found || (mom[r*MOM_W +: MOM_W] > best_mom))) begin
          found    = 1'b1;
          win_id   = IDX_W'(r);
          best_mom = mom[r*MOM_W +: MOM_W];
        end
      end
      if (found) act = ACT_STEAL;
    end
  end

  always_comb begin
    next_oh = owner_oh;
    lose_oh = '0;
    case (act)
      ACT_FREE:  next_oh = '0;
      ACT_TAKE:  next_oh = NUM_REQ'(1) << win_id;
      ACT_STEAL: begin
        next_oh = NUM_REQ'(1) << win_id;
        lose_oh = owner_oh;
      end
      default:   next_oh = owner_oh;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_v  <= 1'b0;
      own_id <= '0;
    end else begin
      case (act)
        ACT_FREE: own_v <= 1'b0;
        ACT_TAKE, ACT_STEAL: begin
          own_v  <= 1'b1;
          own_id <= win_id;
        end
        default: own_v <= own_v;
      endcase
    end
  end

  // Delayed copies used by the checks below
  logic [NUM_REQ*MOM_W-1:0] mom_d;
  logic [IDX_W-1:0]         id_d;
  logic                     v_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      mom_d <= '0;
      id_d  <= '0;
      v_d   <= 1'b0;
    end else begin
      mom_d <= mom;
      id_d  <= own_id;
      v_d   <= own_v;
    end
  end

  // R4
  steal_needs_more_chk: assert property (@(posedge clk) disable iff (rst)
    (own_v && v_d && (own_id != id_d)) |->
      (mom_d[int'(own_id)*MOM_W +: MOM_W] > mom_d[int'(id_d)*MOM_W +: MOM_W]));

  // R8
  freed_on_done_chk: assert property (@(posedge clk) disable iff (rst)
    (own_v && done[own_id]) |=> !own_v);

endmodule

// File: rtl/occ_req_track.sv
module occ_req_track #(
  parameter int NUM_NODES = 8,
  parameter int MOM_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid,
  input  logic                 done,
  input  logic [NUM_NODES-1:0] set,
  input  logic [NUM_NODES-1:0] held_now,
  input  logic [NUM_NODES-1:0] held_next,
  input  logic                 lose_any,
  output logic [MOM_W-1:0]     mom_q,
  output logic                 grant_q,
  output logic                 steal_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mom_q   <= '0;
      grant_q <= 1'b0;
      steal_q <= 1'b0;
    end else begin
      mom_q   <= MOM_W'($countones(held_next));
      grant_q <= valid && !done && (|set) && (held_next == set);
      steal_q <= lose_any;
    end
  end

  // R3
  mom_count_chk: assert property (@(posedge clk) disable iff (rst)
    mom_q == MOM_W'($countones(held_now)));

  // R6
  steal_lost_node_chk: assert property (@(posedge clk) disable iff (rst)
    steal_q |-> (|($past(held_now) & ~held_now)));

  // R7
  grant_full_chk: assert property (@(posedge clk) disable iff (rst)
    grant_q |-> ((held_now == $past(set)) && (|held_now)));

endmodule

// File: rtl/occ_momentum_arbiter.sv
module occ_momentum_arbiter #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_NODES = 8,
  parameter int MOM_W     = $clog2(NUM_NODES + 1)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_REQ-1:0]           req_valid,
  input  logic [NUM_REQ*NUM_NODES-1:0] commit_set,
  input  logic [NUM_REQ-1:0]           commit_done,
  output logic [NUM_REQ*NUM_NODES-1:0] held,
  output logic [NUM_REQ*MOM_W-1:0]     momentum,
  output logic [NUM_REQ-1:0]           all_held,
  output logic [NUM_REQ-1:0]           stolen
);

  logic [NUM_REQ-1:0]   want_n [NUM_NODES];
  logic [NUM_REQ-1:0]   own_n  [NUM_NODES];
  logic [NUM_REQ-1:0]   nx_n   [NUM_NODES];
  logic [NUM_REQ-1:0]   lose_n [NUM_NODES];
  logic [NUM_NODES-1:0] held_rn [NUM_REQ];
  logic [NUM_NODES-1:0] nx_rn   [NUM_REQ];
  logic [NUM_REQ-1:0]   lose_any;

  // Per-node contender vectors
  always_comb begin
    for (int n = 0; n < NUM_NODES; n++) begin
      for (int r = 0; r < NUM_REQ; r++) begin
        want_n[n][r] = req_valid[r] & commit_set[r*NUM_NODES+n] & ~commit_done[r];
      end
    end
  end

  // Node view to requester view
  always_comb begin
    for (int r = 0; r < NUM_REQ; r++) begin
      lose_any[r] = 1'b0;
      for (int n = 0; n < NUM_NODES; n++) begin
        held_rn[r][n] = own_n[n][r];
        nx_rn[r][n]   = nx_n[n][r];
        lose_any[r]   = lose_any[r] | lose_n[n][r];
      end
    end
  end

  for (genvar n = 0; n < NUM_NODES; n++) begin : g_node
    occ_node_slot #(
      .NUM_REQ (NUM_REQ),
      .MOM_W   (MOM_W)
    ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .want     (want_n[n]),
      .done     (commit_done),
      .mom      (momentum),
      .owner_oh (own_n[n]),
      .next_oh  (nx_n[n]),
      .lose_oh  (lose_n[n])
    );
  end

  for (genvar r = 0; r < NUM_REQ; r++) begin : g_req
    assign held[r*NUM_NODES +: NUM_NODES] = held_rn[r];

    occ_req_track #(
      .NUM_NODES (NUM_NODES),
      .MOM_W     (MOM_W)
    ) u_trk (
      .clk       (clk),
      .rst       (rst),
      .valid     (req_valid[r]),
      .done      (commit_done[r]),
      .set       (commit_set[r*NUM_NODES +: NUM_NODES]),
      .held_now  (held_rn[r]),
      .held_next (nx_rn[r]),
      .lose_any  (lose_any[r]),
      .mom_q     (momentum[r*MOM_W +: MOM_W]),
      .grant_q   (all_held[r]),
      .steal_q   (stolen[r])
    );

    for (genvar n = 0; n < NUM_NODES; n++) begin : g_bit
      // R10
      gain_needs_request_chk: assert property (@(posedge clk) disable iff (rst)
        (held_rn[r][n] && !$past(held_rn[r][n])) |->
          $past(req_valid[r] && commit_set[r*NUM_NODES+n] && !commit_done[r]));
    end
  end

endmodule

// File: tb/tb_occ_momentum_arbiter.sv
module tb_occ_momentum_arbiter;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam int NN = 8;
  localparam int MW = 4;
  localparam int NV = 19;

  // {valid[4], done[4], set[32], exp_held[32], exp_grant[4], exp_steal[4]}
  // byte k of set/held belongs to requester k
  localparam logic [79:0] VEC [NV] = '{
    {4'b0011, 4'b0000, 32'h0000_030F, 32'h0000_000F, 4'b0001, 4'b0000}, // R2 lowest index wins free nodes
    {4'b0011, 4'b0000, 32'h0000_030F, 32'h0000_000F, 4'b0001, 4'b0000}, // R4 lower momentum no steal
    {4'b0011, 4'b0001, 32'h0000_030F, 32'h0000_0000, 4'b0000, 4'b0000}, // R8 release, no same-cycle take
    {4'b0111, 4'b0000, 32'h00C0_0330, 32'h00C0_0330, 4'b0111, 4'b0000}, // R2 parallel acquisition
    {4'b0111, 4'b0000, 32'h00C0_1330, 32'h00C0_0330, 4'b0101, 4'b0000}, // R4 equal momentum no steal
    {4'b0111, 4'b0000, 32'h00C0_1B30, 32'h00C0_0B30, 4'b0101, 4'b0000}, // R11 new node not counted yet
    {4'b0111, 4'b0000, 32'h00C0_1B30, 32'h00C0_1B20, 4'b0110, 4'b0001}, // R4 steal with greater momentum
    {4'b0111, 4'b0000, 32'h00C0_1B30, 32'h00C0_1B20, 4'b0110, 4'b0000}, // R6 pulse lasts one cycle
    {4'b0111, 4'b0000, 32'h00E0_3B30, 32'h00C0_3B00, 4'b0010, 4'b0001}, // R5 highest momentum wins
    {4'b0111, 4'b0010, 32'h00E0_3B30, 32'h00C0_0000, 4'b0000, 4'b0000}, // R8 done frees all
    {4'b0101, 4'b0000, 32'h00E0_0030, 32'h00C0_0030, 4'b0001, 4'b0000}, // R2 tie on free node
    {4'b1101, 4'b0000, 32'h0FE0_0030, 32'h0FC0_0030, 4'b1001, 4'b0000}, // R4 equal again
    {4'b1101, 4'b0000, 32'h2FE0_0030, 32'h2FC0_0010, 4'b1000, 4'b0001}, // R5 only greater contender steals
    {4'b1101, 4'b0001, 32'h2FD0_0030, 32'h2FC0_0000, 4'b1000, 4'b0000}, // R8 done beats steal
    {4'b1100, 4'b0000, 32'h2FD0_0000, 32'h2FD0_0000, 4'b1100, 4'b0000}, // R8 freed node taken next edge
    {4'b1100, 4'b1100, 32'h2FD0_0000, 32'h0000_0000, 4'b0000, 4'b0000}, // R8 two releases
    {4'b0111, 4'b0000, 32'h0030_0601, 32'h0030_0601, 4'b0111, 4'b0000}, // R2 disjoint grants
    {4'b0111, 4'b0000, 32'h0031_0701, 32'h0030_0700, 4'b0010, 4'b0001}, // R5 tie goes to lowest index
    {4'b0111, 4'b0000, 32'h0031_0701, 32'h0030_0700, 4'b0010, 4'b0000}  // R6 victim keeps asking
  };

  logic              clk = 1'b0;
  logic              rst;
  logic [NR-1:0]     req_valid;
  logic [NR*NN-1:0]  commit_set;
  logic [NR-1:0]     commit_done;
  logic [NR*NN-1:0]  held;
  logic [NR*MW-1:0]  momentum;
  logic [NR-1:0]     all_held;
  logic [NR-1:0]     stolen;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  occ_momentum_arbiter #(.NUM_REQ(NR), .NUM_NODES(NN)) dut (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .commit_set  (commit_set),
    .commit_done (commit_done),
    .held        (held),
    .momentum    (momentum),
    .all_held    (all_held),
    .stolen      (stolen)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [NR*MW-1:0] count_mom(input logic [NR*NN-1:0] h);
    logic [NR*MW-1:0] m;
    for (int r = 0; r < NR; r++) m[r*MW +: MW] = MW'($countones(h[r*NN +: NN]));
    return m;
  endfunction

  function automatic logic [NN-1:0] overlap(input logic [NR*NN-1:0] h);
    logic [NN-1:0] o = '0;
    for (int a = 0; a < NR; a++)
      for (int b = a + 1; b < NR; b++)
        o = o | (h[a*NN +: NN] & h[b*NN +: NN]);
    return o;
  endfunction

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R9 watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = '0;
    commit_set = '0;
    commit_done = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9", "held", held, 32'h0);
    check("R9", "momentum", 32'(momentum), 32'h0);
    check("R9", "all_held", 32'(all_held), 32'h0);
    check("R9", "stolen", 32'(stolen), 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [3:0]  v, d, g, s;
      logic [31:0] cs, eh;
      {v, d, cs, eh, g, s} = VEC[i];
      req_valid   = v;
      commit_done = d;
      commit_set  = cs;
      @(negedge clk);
      check("R2", $sformatf("held step %0d", i + 1), held, eh);
      check("R7", $sformatf("all_held step %0d", i + 1), 32'(all_held), 32'(g));
      check("R6", $sformatf("stolen step %0d", i + 1), 32'(stolen), 32'(s));
      check("R3", $sformatf("momentum step %0d", i + 1), 32'(momentum), 32'(count_mom(eh)));
      check("R1", $sformatf("overlap step %0d", i + 1), 32'(overlap(held)), 32'h0);
    end

    // R7 empty commit set never grants
    req_valid   = 4'b0111;
    commit_done = 4'b0000;
    commit_set  = 32'h0031_0700;
    @(negedge clk);
    check("R7", "empty set grant", 32'(all_held), 32'h2);
    check("R10", "held after empty set", held, 32'h0030_0700);

    // R9 reset in mid run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R9", "held after reset", held, 32'h0);
    check("R9", "momentum after reset", 32'(momentum), 32'h0);
    check("R9", "all_held after reset", 32'(all_held), 32'h0);
    check("R9", "stolen after reset", 32'(stolen), 32'h0);

    // R2 fresh contention after reset: node 0 goes to requester 1
    @(negedge clk);
    check("R2", "held after restart", held, 32'h0030_0700);
    check("R7", "all_held after restart", 32'(all_held), 32'h2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule